// File: doc/BRIEF.md
# DMA Channel Interrupt Register Unit

This block collects the interrupt events of one DMA channel and turns them into a single level-sensitive interrupt request. There are three event inputs: finishing a transmit descriptor, finishing a receive descriptor, and the end of a received packet. The channel datapath pulses each input for one cycle, and each event sets fixed bits in a sticky raw status register. A mask register selects which status bits may raise the interrupt line. Software clears status through an acknowledge register. The acknowledge register clears only the bits written as one, and it never holds a value of its own.

Software reaches the unit through a simple register port of 32-bit word accesses. A write is a one-cycle strobe with an address and data. Reads are combinational from the address. The word offsets are fixed so that driver code can decode them: 0x8C for the mask, 0x90 for the acknowledge, 0x94 for the raw status and 0x98 for the masked status. The two low address bits are ignored. Any other address reads as zero and ignores writes.

Top module: `dma_irq_unit`

## Requirements
- R1: After reset the raw status, the mask and the interrupt output are all zero, and reading the mask, raw status or masked status returns zero.
- R2: A one-cycle pulse on `txDescDone` sets raw status bit 2 at the next rising clock edge.
- R3: A pulse on `rxDescDone` sets raw status bits 0 and 1 together at the next edge.
- R4: A pulse on `rxPktEnd` sets raw status bit 3 at the next edge.
- R5: A write to offset 0x90 clears every raw status bit whose data bit is one and leaves every other bit unchanged. Status bits never clear in any other way.
- R6: Reading offset 0x90 always returns zero, including right after a write to it.
- R7: Reading offset 0x98 returns the raw status ANDed with the mask. Reading 0x94 returns the raw status, and reading 0x8C returns the mask. Bits 31:4 read as zero.
- R8: `irqOut` is high exactly when the masked status is nonzero. It follows a mask write or an acknowledge write at the clock edge that takes the write.
- R9: When an event and an acknowledge of the same bit fall in the same cycle, the event wins and the bit stays set.
- R10: Writes to offsets 0x94 and 0x98 change neither the raw status nor the mask.
- R11: A write to offset 0x8C stores data bits 3:0 as the new mask. Data bits 31:4 are dropped.
- R12: Events that arrive in the same cycle all take effect, so all three together set bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | ADDR_W (8) | Byte address of the register access |
| regWrEn | input | 1 | One-cycle write strobe |
| regWrData | input | DATA_W (32) | Write data |
| regRdData | output | DATA_W (32) | Read data for `regAddr`, combinational |
| txDescDone | input | 1 | Pulse: a transmit descriptor with its interrupt flag has completed |
| rxDescDone | input | 1 | Pulse: a receive descriptor with its interrupt flag has completed |
| rxPktEnd | input | 1 | Pulse: a receive end-of-packet |
| irqOut | output | 1 | Level interrupt request |

## Verification
The bound checker watches several rules on every cycle:
- each event sets its bits at the next edge, and the receive event sets both of its bits;
- an acknowledge clears its ones when no event collides with it;
- status bits never fall without an acknowledge;
- the interrupt line always equals the OR of raw status ANDed with the mask;
- the acknowledge address reads zero and the masked address reads the gated value;
- writes to the status addresses leave the state unchanged.

Some behaviours only the bench scenarios can show. These are the reset values, the sweep of every raw status pattern against every mask, the sweep of every acknowledge value against every pattern, and the same-cycle collision between an event and an acknowledge of its bit.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  // Number of status bits; the bit meanings below are fixed by software.
  localparam int STAT_W = 4;

  localparam int BIT_RX_A = 0;
  localparam int BIT_RX_B = 1;
  localparam int BIT_TX   = 2;
  localparam int BIT_EOP  = 3;

  // Byte offsets decoded by driver software.
  localparam logic [7:0] OFF_MASK   = 8'h8C;
  localparam logic [7:0] OFF_ACK    = 8'h90;
  localparam logic [7:0] OFF_RAW    = 8'h94;
  localparam logic [7:0] OFF_MASKED = 8'h98;

  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_MASK   = 2'd1,
    RD_RAW    = 2'd2,
    RD_MASKED = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic              maskLoad;
    logic              ackLoad;
    logic [STAT_W-1:0] bits;
    rdSel_e            rdSel;
  } irqStrobe_t;

endpackage

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output irqStrobe_t        strobe
);

  localparam int WORD_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] MASK_A   = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] ACK_A    = ADDR_W'(OFF_ACK);
  localparam logic [ADDR_W-1:0] RAW_A    = ADDR_W'(OFF_RAW);
  localparam logic [ADDR_W-1:0] MASKED_A = ADDR_W'(OFF_MASKED);

  logic [WORD_W-1:0] wordIdx;
  logic hitMask, hitAck, hitRaw, hitMasked;

  assign wordIdx   = regAddr[ADDR_W-1:2];
  assign hitMask   = (wordIdx == MASK_A[ADDR_W-1:2]);
  assign hitAck    = (wordIdx == ACK_A[ADDR_W-1:2]);
  assign hitRaw    = (wordIdx == RAW_A[ADDR_W-1:2]);
  assign hitMasked = (wordIdx == MASKED_A[ADDR_W-1:2]);

  always_comb begin
    strobe.maskLoad = regWrEn && hitMask;
    strobe.ackLoad  = regWrEn && hitAck;
    strobe.bits     = regWrData[STAT_W-1:0];
    if (hitMask)        strobe.rdSel = RD_MASK;
    else if (hitRaw)    strobe.rdSel = RD_RAW;
    else if (hitMasked) strobe.rdSel = RD_MASKED;
    else                strobe.rdSel = RD_ZERO;
  end

endmodule

// File: rtl/dma_irq_path.sv
module dma_irq_path
  import dma_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  irqStrobe_t        strobe,
  input  logic              txDescDone,
  input  logic              rxDescDone,
  input  logic              rxPktEnd,
  output logic [STAT_W-1:0] rawQ,
  output logic [STAT_W-1:0] maskQ,
  output logic [DATA_W-1:0] rdData,
  output logic              irqLine
);

  logic [STAT_W-1:0] setVec;
  logic [STAT_W-1:0] maskedStat;

  // Map event pulses onto status bits.
  always_comb begin
    setVec           = '0;
    setVec[BIT_RX_A] = rxDescDone;
    setVec[BIT_RX_B] = rxDescDone;
    setVec[BIT_TX]   = txDescDone;
    setVec[BIT_EOP]  = rxPktEnd;
  end

  // One sticky cell per bit; setting beats clearing.
  for (genvar i = 0; i < STAT_W; i++) begin : g_cell
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                rawQ[i] <= 1'b0;
      else if (setVec[i])                       rawQ[i] <= 1'b1;
      else if (strobe.ackLoad && strobe.bits[i]) rawQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                maskQ <= '0;
    else if (strobe.maskLoad) maskQ <= strobe.bits;
  end

  assign maskedStat = rawQ & maskQ;
  assign irqLine    = |maskedStat;

  always_comb begin
    unique case (strobe.rdSel)
      RD_MASK:   rdData = DATA_W'(maskQ);
      RD_RAW:    rdData = DATA_W'(rawQ);
      RD_MASKED: rdData = DATA_W'(maskedStat);
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              txDescDone,
  input  logic              rxDescDone,
  input  logic              rxPktEnd,
  output logic              irqOut
);

  irqStrobe_t        strobe;
  logic [STAT_W-1:0] rawQ;
  logic [STAT_W-1:0] maskQ;

  dma_irq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .strobe    (strobe)
  );

  dma_irq_path #(.DATA_W(DATA_W)) path_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .txDescDone (txDescDone),
    .rxDescDone (rxDescDone),
    .rxPktEnd   (rxPktEnd),
    .rawQ       (rawQ),
    .maskQ      (maskQ),
    .rdData     (regRdData),
    .irqLine    (irqOut)
  );

endmodule

// File: rtl/dma_irq_unit_chk.sv
module dma_irq_unit_chk
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              txDescDone,
  input logic              rxDescDone,
  input logic              rxPktEnd,
  input logic              irqOut,
  input logic [STAT_W-1:0] rawQ,
  input logic [STAT_W-1:0] maskQ
);

  logic atAck, atRaw, atMasked, anyEvt;
  assign atAck    = (regAddr[ADDR_W-1:2] == ADDR_W'(OFF_ACK) >> 2);
  assign atRaw    = (regAddr[ADDR_W-1:2] == ADDR_W'(OFF_RAW) >> 2);
  assign atMasked = (regAddr[ADDR_W-1:2] == ADDR_W'(OFF_MASKED) >> 2);
  assign anyEvt   = txDescDone || rxDescDone || rxPktEnd;

  a_r2_tx_sets: assert property (@(posedge clk) disable iff (!rstN)
    txDescDone |=> rawQ[BIT_TX]);

  a_r3_rx_sets_pair: assert property (@(posedge clk) disable iff (!rstN)
    rxDescDone |=> (rawQ[BIT_RX_B:BIT_RX_A] == 2'b11));

  a_r4_eop_sets: assert property (@(posedge clk) disable iff (!rstN)
    rxPktEnd |=> rawQ[BIT_EOP]);

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && atAck && !anyEvt) |=> ((rawQ & $past(regWrData[STAT_W-1:0])) == '0));

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && atAck) |=> ((rawQ & $past(rawQ)) == $past(rawQ)));

  a_r6_ack_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    atAck |-> (regRdData == '0));

  a_r7_masked_read: assert property (@(posedge clk) disable iff (!rstN)
    atMasked |-> (regRdData == DATA_W'(rawQ & maskQ)));

  a_r8_irq_level: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == ((rawQ & maskQ) != '0));

  a_r10_status_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (atRaw || atMasked) && !anyEvt) |=> ($stable(rawQ) && $stable(maskQ)));

endmodule

bind dma_irq_unit dma_irq_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .regAddr    (regAddr),
  .regWrEn    (regWrEn),
  .regWrData  (regWrData),
  .regRdData  (regRdData),
  .txDescDone (txDescDone),
  .rxDescDone (rxDescDone),
  .rxPktEnd   (rxPktEnd),
  .irqOut     (irqOut),
  .rawQ       (rawQ),
  .maskQ      (maskQ)
);

// File: tb/dma_irq_unit_tb_top.sv
module dma_irq_unit_tb_top;

  localparam logic [7:0] A_MASK   = 8'h8C;
  localparam logic [7:0] A_ACK    = 8'h90;
  localparam logic [7:0] A_RAW    = 8'h94;
  localparam logic [7:0] A_MASKED = 8'h98;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        txDescDone = 1'b0;
  logic        rxDescDone = 1'b0;
  logic        rxPktEnd = 1'b0;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dma_irq_unit dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .txDescDone(txDescDone),
    .rxDescDone(rxDescDone), .rxPktEnd(rxPktEnd), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic pulse(input logic tx, input logic rx, input logic eop);
    @(negedge clk);
    txDescDone = tx; rxDescDone = rx; rxPktEnd = eop;
    @(negedge clk);
    txDescDone = 1'b0; rxDescDone = 1'b0; rxPktEnd = 1'b0;
  endtask

  // Drive raw status to pattern p using events then an acknowledge (R12).
  task automatic makeRaw(input logic [3:0] p);
    wrReg(A_ACK, 32'hF);
    pulse(p[2], p[0] | p[1], p[3]);
    wrReg(A_ACK, {28'd0, ~p});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdReg(A_RAW, rd);    check("R1 raw", rd, 32'h0);
    rdReg(A_MASK, rd);   check("R1 mask", rd, 32'h0);
    rdReg(A_MASKED, rd); check("R1 masked", rd, 32'h0);
    check("R1 irq", {31'd0, irqOut}, 32'h0);

    // R2, R3, R4 individual events
    pulse(1'b1, 1'b0, 1'b0);
    rdReg(A_RAW, rd); check("R2 tx bit2", rd, 32'h4);
    wrReg(A_ACK, 32'hF);
    pulse(1'b0, 1'b1, 1'b0);
    rdReg(A_RAW, rd); check("R3 rx bits0,1", rd, 32'h3);
    wrReg(A_ACK, 32'hF);
    pulse(1'b0, 1'b0, 1'b1);
    rdReg(A_RAW, rd); check("R4 eop bit3", rd, 32'h8);
    pulse(1'b1, 1'b1, 1'b1);
    rdReg(A_RAW, rd); check("R12 all events", rd, 32'hF);

    // R11 mask stores low bits only
    wrReg(A_MASK, 32'hFFFF_FFF5);
    rdReg(A_MASK, rd); check("R11 mask low bits", rd, 32'h5);

    // R6 ack reads zero right after a write
    wrReg(A_ACK, 32'h0);
    rdReg(A_ACK, rd); check("R6 ack read", rd, 32'h0);
    wrReg(A_ACK, 32'h2);
    rdReg(A_ACK, rd); check("R6 ack read after write", rd, 32'h0);
    rdReg(A_RAW, rd); check("R5 only bit1 cleared", rd, 32'hD);

    // R10 writes to status addresses ignored
    wrReg(A_RAW, 32'h0);
    rdReg(A_RAW, rd); check("R10 raw write ignored", rd, 32'hD);
    wrReg(A_MASKED, 32'h0);
    rdReg(A_RAW, rd); check("R10 masked write raw", rd, 32'hD);
    rdReg(A_MASK, rd); check("R10 masked write mask", rd, 32'h5);

    // R9 event beats same-cycle acknowledge
    @(negedge clk);
    regAddr = A_ACK; regWrData = 32'hF; regWrEn = 1'b1; txDescDone = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; txDescDone = 1'b0;
    rdReg(A_RAW, rd); check("R9 collision", rd, 32'h4);
    @(negedge clk);
    regAddr = A_ACK; regWrData = 32'h3; regWrEn = 1'b1; rxDescDone = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; rxDescDone = 1'b0;
    rdReg(A_RAW, rd); check("R9 rx collision", rd, 32'h7);

    // Sweep raw pattern x mask (R7, R8)
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 16; m++) begin
        makeRaw(4'(p));
        wrReg(A_MASK, 32'(m));
        rdReg(A_RAW, rd);    check("R7 raw", rd, 32'(p));
        rdReg(A_MASKED, rd); check("R7 masked", rd, 32'(p & m));
        check("R8 irq", {31'd0, irqOut}, {31'd0, (p & m) != 0});
      end
    end

    // Sweep pattern x ack value (R5)
    for (int p = 0; p < 16; p++) begin
      for (int a = 0; a < 16; a++) begin
        makeRaw(4'(p));
        wrReg(A_ACK, 32'(a) | 32'hFFFF_FFF0);
        rdReg(A_RAW, rd); check("R5 ack sweep", rd, 32'(p & ~a & 15));
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule